// File: doc/BRIEF.md
# Branch Target Buffer Fetch Predictor

This block sits beside the fetch program counter and answers, in the same cycle, where fetch should go next. It keeps a small direct-mapped table. Each table entry holds four things: a tag, a remembered branch destination, a branch category, and a one-bit record of the branch's most recent direction. When the current program counter finds a valid entry with a matching tag, the instruction is reported as a branch and its category is shown. The next fetch address is then the stored destination if the last recorded outcome was taken, or the sequential address if it was not taken. When there is no match, fetch simply advances by one 4-byte instruction.

The execute side reports each resolved branch through an update port. The update allocates the indexed entry, or overwrites it, with the new tag, destination, category and actual direction. A write lands at the clock edge, so a lookup in the same cycle still sees the earlier contents.

The direction record of each entry is a two-state machine. `DIR_NOT_TAKEN` is the reset state and means the branch is predicted sequential. `DIR_TAKEN` means the branch is predicted to redirect to the stored destination. Only a resolving update to that entry changes the state. The `RESOLVE_TAKEN` transition enters `DIR_TAKEN` from either state. The `RESOLVE_NOT_TAKEN` transition enters `DIR_NOT_TAKEN` from either state. Without an update, the state holds.

Top module: `btb_fetch_pred`

## Requirements
- R1: While reset is active and after it is released, every entry is invalid, so every lookup misses until an update is written.
- R2: The entry index is fetch address bits [5:2] and the stored tag is bits [31:6]; bits [1:0] take no part in the lookup, and a hit needs a valid entry whose tag equals the upper address bits.
- R3: On a miss, hit_o and pred_taken_o are 0 and next_pc_o equals fetch_pc_i + 4.
- R4: On a hit whose direction state is DIR_TAKEN, pred_taken_o is 1 and next_pc_o equals the stored destination.
- R5: On a hit whose direction state is DIR_NOT_TAKEN, pred_taken_o is 0 and next_pc_o equals fetch_pc_i + 4.
- R6: An update with upd_valid_i high writes valid, tag, destination, category and direction into the entry indexed by upd_pc_i, whether the entry was free or held another branch.
- R7: Every update replaces the direction with the reported outcome, with no hysteresis: a single opposite outcome flips the prediction.
- R8: On a hit, kind_o shows the stored category with the encoding 0 conditional, 1 unconditional jump, 2 call, 3 return, 4 indirect; on a miss kind_o is 0.
- R9: A lookup and an update to the same entry in the same cycle return the contents held before the update; the new contents are visible from the next cycle.
- R10: A lookup whose index matches an entry but whose tag differs misses, and an update with a different tag evicts the previous branch from that entry.
- R11: The sequential address wraps modulo 2^32, so a miss at 0xFFFFFFFC gives next_pc_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc_i | input | 32 | Program counter being fetched this cycle |
| hit_o | output | 1 | Fetched instruction is a known branch |
| kind_o | output | 3 | Category of the hit branch, 0 on a miss |
| pred_taken_o | output | 1 | Prediction redirects to the stored destination |
| next_pc_o | output | 32 | Address to fetch next cycle |
| upd_valid_i | input | 1 | A resolved branch is reported this cycle |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual direction of the resolved branch |
| upd_target_i | input | 32 | Actual destination of the resolved branch |
| upd_kind_i | input | 3 | Category of the resolved branch |

## Verification
The properties assume that upd_kind_i carries only the five defined category codes. They also assume that the update inputs are held low during reset, so that no entry can be valid on the first cycle after release. The stimulus writes only the codes 0 to 4 and drives the update port idle around every reset. The write-then-read property assumes that one cycle's update is the only write between it and the following lookup. The bench respects this by issuing at most one update per cycle, and it checks same-index collisions against its own table model.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [2:0] {
        BK_COND     = 3'd0,
        BK_JUMP     = 3'd1,
        BK_CALL     = 3'd2,
        BK_RET      = 3'd3,
        BK_INDIRECT = 3'd4
    } branch_kind_e;

    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } dir_state_e;

endpackage

// File: rtl/btb_dir_fsm.sv
module btb_dir_fsm
    import btb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic resolve_i,
    input  logic outcome_i,
    output logic predict_taken_o
);

    dir_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIR_NOT_TAKEN: if (resolve_i && outcome_i)  state_d = DIR_TAKEN;
            DIR_TAKEN:     if (resolve_i && !outcome_i) state_d = DIR_NOT_TAKEN;
            default:       state_d = DIR_NOT_TAKEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DIR_NOT_TAKEN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            DIR_TAKEN: predict_taken_o = 1'b1;
            default:   predict_taken_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 2,
    parameter int IDX_W  = 4,
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [TAG_W-1:0]  tag_o
);

    logic unused_ofs;

    assign idx_o      = addr_i[OFS_W +: IDX_W];
    assign tag_o      = addr_i[ADDR_W-1 -: TAG_W];
    assign unused_ofs = ^addr_i[OFS_W-1:0];

endmodule

// File: rtl/btb_entry_array.sv
module btb_entry_array #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 26,
    parameter int KIND_W  = 3,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              rd_valid_o,
    output logic [TAG_W-1:0]  rd_tag_o,
    output logic [ADDR_W-1:0] rd_target_o,
    output logic [KIND_W-1:0] rd_kind_o,
    output logic              rd_taken_o,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [TAG_W-1:0]  wr_tag_i,
    input  logic [ADDR_W-1:0] wr_target_i,
    input  logic [KIND_W-1:0] wr_kind_i,
    input  logic              wr_taken_i
);

    logic              valid_q  [ENTRIES];
    logic [TAG_W-1:0]  tag_q    [ENTRIES];
    logic [ADDR_W-1:0] target_q [ENTRIES];
    logic [KIND_W-1:0] kind_q   [ENTRIES];
    logic              dir_w    [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic sel;
        assign sel = wr_en_i && (wr_idx_i == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[e] <= 1'b0;
            end else if (sel) begin
                valid_q[e] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[e]    <= wr_tag_i;
                target_q[e] <= wr_target_i;
                kind_q[e]   <= wr_kind_i;
            end
        end

        btb_dir_fsm u_dir (
            .clk             (clk),
            .rst_n           (rst_n),
            .resolve_i       (sel),
            .outcome_i       (wr_taken_i),
            .predict_taken_o (dir_w[e])
        );
    end

    assign rd_valid_o  = valid_q[rd_idx_i];
    assign rd_tag_o    = tag_q[rd_idx_i];
    assign rd_target_o = target_q[rd_idx_i];
    assign rd_kind_o   = kind_q[rd_idx_i];
    assign rd_taken_o  = dir_w[rd_idx_i];

endmodule

// File: rtl/btb_next_sel.sv
module btb_next_sel #(
    parameter int ADDR_W      = 32,
    parameter int TAG_W       = 26,
    parameter int KIND_W      = 3,
    parameter int INSTR_BYTES = 4
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [TAG_W-1:0]  pc_tag_i,
    input  logic              ent_valid_i,
    input  logic [TAG_W-1:0]  ent_tag_i,
    input  logic [ADDR_W-1:0] ent_target_i,
    input  logic [KIND_W-1:0] ent_kind_i,
    input  logic              ent_taken_i,
    output logic              hit_o,
    output logic [KIND_W-1:0] kind_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] next_o
);

    logic [ADDR_W-1:0] seq_addr;

    assign seq_addr = pc_i + ADDR_W'(INSTR_BYTES);
    assign hit_o    = ent_valid_i && (ent_tag_i == pc_tag_i);
    assign taken_o  = hit_o && ent_taken_i;
    assign kind_o   = hit_o ? ent_kind_i : '0;
    assign next_o   = taken_o ? ent_target_i : seq_addr;

endmodule

// File: rtl/btb_fetch_pred.sv
module btb_fetch_pred #(
    parameter int ADDR_W      = 32,
    parameter int ENTRIES     = 16,
    parameter int INSTR_BYTES = 4,
    parameter int KIND_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc_i,
    output logic              hit_o,
    output logic [KIND_W-1:0] kind_o,
    output logic              pred_taken_o,
    output logic [ADDR_W-1:0] next_pc_o,
    input  logic              upd_valid_i,
    input  logic [ADDR_W-1:0] upd_pc_i,
    input  logic              upd_taken_i,
    input  logic [ADDR_W-1:0] upd_target_i,
    input  logic [KIND_W-1:0] upd_kind_i
);

    localparam int OFS_W = $clog2(INSTR_BYTES);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [TAG_W-1:0]  rd_tag, wr_tag;
    logic              ent_valid, ent_taken;
    logic [TAG_W-1:0]  ent_tag;
    logic [ADDR_W-1:0] ent_target;
    logic [KIND_W-1:0] ent_kind;

    btb_addr_split #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_rd_split (
        .addr_i (fetch_pc_i),
        .idx_o  (rd_idx),
        .tag_o  (rd_tag)
    );

    btb_addr_split #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_wr_split (
        .addr_i (upd_pc_i),
        .idx_o  (wr_idx),
        .tag_o  (wr_tag)
    );

    btb_entry_array #(
        .ADDR_W (ADDR_W), .ENTRIES (ENTRIES), .TAG_W (TAG_W), .KIND_W (KIND_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx_i    (rd_idx),
        .rd_valid_o  (ent_valid),
        .rd_tag_o    (ent_tag),
        .rd_target_o (ent_target),
        .rd_kind_o   (ent_kind),
        .rd_taken_o  (ent_taken),
        .wr_en_i     (upd_valid_i),
        .wr_idx_i    (wr_idx),
        .wr_tag_i    (wr_tag),
        .wr_target_i (upd_target_i),
        .wr_kind_i   (upd_kind_i),
        .wr_taken_i  (upd_taken_i)
    );

    btb_next_sel #(
        .ADDR_W (ADDR_W), .TAG_W (TAG_W), .KIND_W (KIND_W), .INSTR_BYTES (INSTR_BYTES)
    ) u_sel (
        .pc_i         (fetch_pc_i),
        .pc_tag_i     (rd_tag),
        .ent_valid_i  (ent_valid),
        .ent_tag_i    (ent_tag),
        .ent_target_i (ent_target),
        .ent_kind_i   (ent_kind),
        .ent_taken_i  (ent_taken),
        .hit_o        (hit_o),
        .kind_o       (kind_o),
        .taken_o      (pred_taken_o),
        .next_o       (next_pc_o)
    );

endmodule

// File: rtl/btb_fetch_pred_chk.sv
module btb_fetch_pred_chk #(
    parameter int ADDR_W      = 32,
    parameter int INSTR_BYTES = 4,
    parameter int KIND_W      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_pc_i,
    input logic              hit_o,
    input logic [KIND_W-1:0] kind_o,
    input logic              pred_taken_o,
    input logic [ADDR_W-1:0] next_pc_o,
    input logic              upd_valid_i,
    input logic [ADDR_W-1:0] upd_pc_i,
    input logic              upd_taken_i,
    input logic [ADDR_W-1:0] upd_target_i,
    input logic [KIND_W-1:0] upd_kind_i
);

    localparam int OFS_W = $clog2(INSTR_BYTES);

    assert_cold_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !hit_o);

    assert_miss_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (!pred_taken_o && next_pc_o == fetch_pc_i + ADDR_W'(INSTR_BYTES)));

    assert_taken_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken_o |-> hit_o);

    assert_not_taken_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && !pred_taken_o) |-> next_pc_o == fetch_pc_i + ADDR_W'(INSTR_BYTES));

    assert_write_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_valid_i) && fetch_pc_i[ADDR_W-1:OFS_W] == $past(upd_pc_i[ADDR_W-1:OFS_W]))
        |-> (hit_o && kind_o == $past(upd_kind_i) && pred_taken_o == $past(upd_taken_i)
             && (!pred_taken_o || next_pc_o == $past(upd_target_i))));

    assert_kind_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> kind_o <= KIND_W'(4));

    assert_kind_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> kind_o == '0);

endmodule

bind btb_fetch_pred btb_fetch_pred_chk #(
    .ADDR_W (ADDR_W), .INSTR_BYTES (INSTR_BYTES), .KIND_W (KIND_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_pc_i   (fetch_pc_i),
    .hit_o        (hit_o),
    .kind_o       (kind_o),
    .pred_taken_o (pred_taken_o),
    .next_pc_o    (next_pc_o),
    .upd_valid_i  (upd_valid_i),
    .upd_pc_i     (upd_pc_i),
    .upd_taken_i  (upd_taken_i),
    .upd_target_i (upd_target_i),
    .upd_kind_i   (upd_kind_i)
);

// File: tb/sim_btb_fetch_pred.sv
module sim_btb_fetch_pred;

    localparam int CLK_PERIOD = 10;
    localparam int NENT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc_i = '0;
    logic        hit_o, pred_taken_o;
    logic [2:0]  kind_o;
    logic [31:0] next_pc_o;
    logic        upd_valid_i = 1'b0;
    logic [31:0] upd_pc_i = '0;
    logic        upd_taken_i = 1'b0;
    logic [31:0] upd_target_i = '0;
    logic [2:0]  upd_kind_i = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btb_fetch_pred u0 (
        .clk (clk), .rst_n (rst_n), .fetch_pc_i (fetch_pc_i),
        .hit_o (hit_o), .kind_o (kind_o), .pred_taken_o (pred_taken_o),
        .next_pc_o (next_pc_o), .upd_valid_i (upd_valid_i), .upd_pc_i (upd_pc_i),
        .upd_taken_i (upd_taken_i), .upd_target_i (upd_target_i), .upd_kind_i (upd_kind_i)
    );

    typedef struct {
        logic        hit;
        logic        taken;
        logic [2:0]  kind;
        logic [31:0] next;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;

    logic        m_valid [NENT];
    logic [25:0] m_tag   [NENT];
    logic [31:0] m_tgt   [NENT];
    logic [2:0]  m_kind  [NENT];
    logic        m_dir   [NENT];

    task automatic model_clear();
        for (int i = 0; i < NENT; i++) m_valid[i] = 1'b0;
    endtask

    task automatic drive(input logic [31:0] pc, input logic uv, input logic [31:0] upc,
                         input logic ut, input logic [31:0] utgt, input logic [2:0] uk,
                         input string req);
        exp_t e;
        int   ix;
        @(negedge clk);
        fetch_pc_i   = pc;
        upd_valid_i  = uv;
        upd_pc_i     = upc;
        upd_taken_i  = ut;
        upd_target_i = utgt;
        upd_kind_i   = uk;
        ix      = int'(pc[5:2]);
        e.hit   = m_valid[ix] && (m_tag[ix] == pc[31:6]);
        e.taken = e.hit && m_dir[ix];
        e.kind  = e.hit ? m_kind[ix] : 3'd0;
        e.next  = e.taken ? m_tgt[ix] : pc + 32'd4;
        e.req   = req;
        exp_q.push_back(e);
        if (uv) begin
            ix = int'(upc[5:2]);
            m_valid[ix] = 1'b1;
            m_tag[ix]   = upc[31:6];
            m_tgt[ix]   = utgt;
            m_kind[ix]  = uk;
            m_dir[ix]   = ut;
        end
    endtask

    task automatic look(input logic [31:0] pc, input string req);
        drive(pc, 1'b0, 32'd0, 1'b0, 32'd0, 3'd0, req);
    endtask

    task automatic upd(input logic [31:0] upc, input logic ut, input logic [31:0] utgt,
                       input logic [2:0] uk, input string req);
        drive(32'h0000_0F00, 1'b1, upc, ut, utgt, uk, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        upd_valid_i = 1'b0;
        rst_n = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                n_checks++;
                if (hit_o !== e.hit || pred_taken_o !== e.taken ||
                    kind_o !== e.kind || next_pc_o !== e.next) begin
                    n_fail++;
                    $display("FAIL %s pc=%h: got hit=%b taken=%b kind=%0d next=%h, expected hit=%b taken=%b kind=%0d next=%h",
                             e.req, fetch_pc_i, hit_o, pred_taken_o, kind_o, next_pc_o,
                             e.hit, e.taken, e.kind, e.next);
                end
            end
        end
    end

    logic done = 1'b0;

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        logic [15:0] lf;
        model_clear();
        do_reset();

        // R1: empty after reset
        look(32'h0000_0100, "R1");
        look(32'h0000_0000, "R1");
        // R3 / R11: sequential, with wrap
        look(32'h1234_5678, "R3");
        look(32'hFFFF_FFFC, "R11");

        // R9: same-cycle lookup sees old (empty) entry
        drive(32'h0000_1000, 1'b1, 32'h0000_1000, 1'b1, 32'h0000_2000, 3'd0, "R9");
        // R4 / R6: visible next cycle, taken -> target
        look(32'h0000_1000, "R4");
        // R7: flip to not taken, R9 same cycle still taken
        drive(32'h0000_1000, 1'b1, 32'h0000_1000, 1'b0, 32'h0000_2000, 3'd0, "R9");
        look(32'h0000_1000, "R5");
        upd(32'h0000_1000, 1'b1, 32'h0000_3000, 3'd0, "R7");
        look(32'h0000_1000, "R7");

        // R2: low bits ignored; R10: alias at same index
        look(32'h0000_1003, "R2");
        look(32'h0000_1040, "R10");
        upd(32'h0000_1040, 1'b0, 32'h0000_5000, 3'd2, "R6");
        look(32'h0000_1000, "R10");
        look(32'h0000_1040, "R10");

        // R8: each category
        upd(32'h0000_2004, 1'b1, 32'h0000_0400, 3'd1, "R8");
        upd(32'h0000_2008, 1'b1, 32'h0000_0800, 3'd3, "R8");
        upd(32'h0000_200C, 1'b1, 32'h0000_0C00, 3'd4, "R8");
        look(32'h0000_2004, "R8");
        look(32'h0000_2008, "R8");
        look(32'h0000_200C, "R8");

        // R2: fill every index, then read back
        for (int i = 0; i < NENT; i++)
            upd(32'h0004_0000 + 32'(i * 4), i[0], 32'h0009_0000 + 32'(i * 16), 3'(i % 5), "R2");
        for (int i = 0; i < NENT; i++)
            look(32'h0004_0000 + 32'(i * 4), "R2");

        // R6 / R7 / R10: pseudo-random mix in a small address window
        lf = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            drive({24'h000A00, lf[7:2], 2'b00}, lf[8],
                  {24'h000A00, lf[13:9], lf[1], 2'b00}, lf[14],
                  {16'h00B0, lf}, 3'(lf[3:0] % 5), "R6");
        end

        // R1: reset again empties the table
        do_reset();
        look(32'h0000_1000, "R1");
        look(32'h0004_0004, "R1");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule